// File: doc/BRIEF.md
# External Interrupt Line Controller

The controller takes up to 32 asynchronous external interrupt lines. Each line passes through a multi-flop synchronizer and then through a detector. The detector's sense mode comes from a configuration word that belongs to that line. A line can be set to detect a low level, a high level, a rising edge, a falling edge or both edges. Any other value in the sense field turns detection off for that line.

Detections are kept in a per-line detect bit. A per-line enable mask gates each detect bit onto a dedicated interrupt output. The same gated value can be read back as a request status word.

Software reaches the block through a synchronous 32-bit register port. Writes take effect on the clock edge. Reads are combinational from the address.

The enable mask is changed through two write-one offsets: one sets bits and the other clears them. The detect word is cleared by writing ones. The per-line configuration words hold all 32 bits that software writes.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, every detect bit and every configuration word is 0, and every interrupt output is 0.
- R2: Writing to offset 0x008 sets each enable bit whose data bit is 1 and leaves the other enable bits unchanged. Reads of offset 0x008 and of offset 0x004 both return the enable mask, with line n at bit n.
- R3: Writing to offset 0x004 clears each enable bit whose data bit is 1 and leaves the other enable bits unchanged.
- R4: Offset 0x000 is read-only and reads as detect AND enable. Interrupt output n equals bit n of that word. A line detects whether or not it is enabled.
- R5: With sense code 0x08 (rising edge), a 0-to-1 change on a line sets its detect bit at the third rising clock edge after the change (two synchronizer flops, then the detect register). The bit stays set until a 1 is written to that bit of offset 0x100.
- R6: Sense code 0x04 detects only 1-to-0 changes. Sense code 0x0C detects changes in both directions. Both use the same latency as R5.
- R7: When an edge detection and a write-one-to-clear of the same line fall on the same clock edge, the detect bit stays set.
- R8: With sense code 0x02 (high) or 0x01 (low), the detect bit follows the line's active level with the latency of R5. A write-one-to-clear has no effect while the level is still active.
- R9: The configuration word for line n is at offset 0x180 + 4*n and reads back all 32 written bits. Bits [5:0] are the sense field. A sense value of 0, or any value not listed in R5, R6 and R8 (for example 0x03), makes the line never detect.
- R10: Unmapped offsets read as 0 and ignore writes. This includes misaligned addresses and configuration slots beyond the last line. Writes to offset 0x000 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | NUM_LINES | External interrupt lines, asynchronous |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | NUM_LINES | Per-line interrupt outputs (detect AND enable) |

## Verification
The hardest case to reach from the ports is the collision in R7. An edge arrives on the same clock edge as a clear of that line's detect bit. The bench counts the synchronizer latency exactly: it changes the pin, waits two rising edges, and then issues the clear so that the write lands on the third edge, where the edge is seen. The detect word read afterwards must still show the bit. The level-mode check that a clear is ignored is done in the same way, by issuing the clear while the synchronized level is still active.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

   localparam int unsigned REG_W   = 32;
   localparam int unsigned SENSE_W = 6;

   localparam int unsigned OFS_REQ     = 'h000;
   localparam int unsigned OFS_EN_CLR  = 'h004;
   localparam int unsigned OFS_EN_SET  = 'h008;
   localparam int unsigned OFS_DET     = 'h100;
   localparam int unsigned OFS_CFG     = 'h180;

   localparam logic [SENSE_W-1:0] SNS_LOW  = 6'h01;
   localparam logic [SENSE_W-1:0] SNS_HIGH = 6'h02;
   localparam logic [SENSE_W-1:0] SNS_FALL = 6'h04;
   localparam logic [SENSE_W-1:0] SNS_RISE = 6'h08;
   localparam logic [SENSE_W-1:0] SNS_BOTH = 6'h0C;

   typedef struct packed {
      logic lvl_hi;
      logic lvl_lo;
      logic on_rise;
      logic on_fall;
   } sense_t;

   function automatic sense_t decode_sense(logic [SENSE_W-1:0] f);
      sense_t m;
      m = '0;
      case (f)
         SNS_LOW:  m.lvl_lo  = 1'b1;
         SNS_HIGH: m.lvl_hi  = 1'b1;
         SNS_FALL: m.on_fall = 1'b1;
         SNS_RISE: m.on_rise = 1'b1;
         SNS_BOTH: begin
            m.on_rise = 1'b1;
            m.on_fall = 1'b1;
         end
         default:  m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("eirq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '0;
         else        stg[s] <= stg[s-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
   import eirq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp,
   input  logic [SENSE_W-1:0] sense,
   input  logic               clr,
   output logic               det
);

   sense_t m;
   logic   prev_q;
   logic   rise, fall, edge_hit;
   logic   lvl_mode, lvl_act;
   logic   det_n;

   always_comb begin
      m        = decode_sense(sense);
      rise     = smp & ~prev_q;
      fall     = ~smp & prev_q;
      edge_hit = (m.on_rise & rise) | (m.on_fall & fall);
      lvl_mode = m.lvl_hi | m.lvl_lo;
      lvl_act  = (m.lvl_hi & smp) | (m.lvl_lo & ~smp);
      if (lvl_mode) det_n = lvl_act;
      else          det_n = edge_hit | (det & ~clr);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         det    <= 1'b0;
      end else begin
         prev_q <= smp;
         det    <= det_n;
      end
   end

   // R5: an edge-mode detection is held while no clear arrives
   p_edge_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && det && !clr) |=> det);

   // R7: an edge seen together with a clear keeps the bit set
   p_edge_beats_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m.on_rise && smp && !prev_q && clr) |=> det);

   // R8: high-level mode with the line high reports a detection next cycle
   p_level_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m.lvl_hi && smp) |=> det);

   // R9: a disabled sense code never raises the detect bit
   p_no_detect_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!lvl_mode && !m.on_rise && !m.on_fall) |=> !$rose(det));

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import eirq_pkg::*;
#(
   parameter int unsigned NUM_LINES   = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic [REG_W-1:0]     bus_rdata,
   output logic [NUM_LINES-1:0] irq_out
);

   localparam int unsigned CFG_END = OFS_CFG + 4 * NUM_LINES;
   localparam int unsigned WADDR_W = ADDR_W - 2;

   if (NUM_LINES < 1 || NUM_LINES > REG_W) begin : g_bad_lines
      $error("ext_irq_ctrl: NUM_LINES must be 1..32");
   end
   if (ADDR_W < 9 || ADDR_W > 30) begin : g_bad_addr_w
      $error("ext_irq_ctrl: ADDR_W must be 9..30");
   end
   if (CFG_END > (1 << ADDR_W)) begin : g_bad_addr_fit
      $error("ext_irq_ctrl: configuration block does not fit ADDR_W");
   end

   function automatic logic [REG_W-1:0] widen(logic [NUM_LINES-1:0] v);
      logic [REG_W-1:0] w;
      w = '0;
      w[NUM_LINES-1:0] = v;
      return w;
   endfunction

   // ---------------- address decode ----------------
   logic               hit_req, hit_clr, hit_set, hit_det, hit_cfg, mapped;
   logic               aligned;
   logic [WADDR_W-1:0] cfg_word;
   logic [NUM_LINES-1:0] cfg_sel;

   always_comb begin
      aligned  = (bus_addr[1:0] == 2'b00);
      hit_req  = (bus_addr == ADDR_W'(OFS_REQ));
      hit_clr  = (bus_addr == ADDR_W'(OFS_EN_CLR));
      hit_set  = (bus_addr == ADDR_W'(OFS_EN_SET));
      hit_det  = (bus_addr == ADDR_W'(OFS_DET));
      hit_cfg  = aligned && (bus_addr >= ADDR_W'(OFS_CFG))
                         && (bus_addr <  ADDR_W'(CFG_END));
      cfg_word = bus_addr[ADDR_W-1:2] - WADDR_W'(OFS_CFG >> 2);
      mapped   = hit_req | hit_clr | hit_set | hit_det | hit_cfg;
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_sel
      assign cfg_sel[i] = hit_cfg && (cfg_word == WADDR_W'(i));
   end

   // ---------------- enable mask ----------------
   logic [NUM_LINES-1:0] en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (bus_we && hit_set) begin
         en_q <= en_q | bus_wdata[NUM_LINES-1:0];
      end else if (bus_we && hit_clr) begin
         en_q <= en_q & ~bus_wdata[NUM_LINES-1:0];
      end
   end

   // ---------------- configuration words ----------------
   logic [REG_W-1:0] cfg_q [NUM_LINES];

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_cfg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cfg_q[i] <= '0;
         else if (bus_we && cfg_sel[i])  cfg_q[i] <= bus_wdata;
      end
   end

   // ---------------- synchronize and detect ----------------
   logic [NUM_LINES-1:0] smp;
   logic [NUM_LINES-1:0] det;
   logic [NUM_LINES-1:0] det_clr;

   assign det_clr = (bus_we && hit_det) ? bus_wdata[NUM_LINES-1:0] : '0;

   eirq_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (smp)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      eirq_detect u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .smp   (smp[i]),
         .sense (cfg_q[i][SENSE_W-1:0]),
         .clr   (det_clr[i]),
         .det   (det[i])
      );
   end

   assign irq_out = det & en_q;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      if (hit_req)               bus_rdata = widen(irq_out);
      else if (hit_clr | hit_set) bus_rdata = widen(en_q);
      else if (hit_det)          bus_rdata = widen(det);
      else begin
         for (int i = 0; i < NUM_LINES; i++) begin
            if (cfg_sel[i]) bus_rdata = bus_rdata | cfg_q[i];
         end
      end
   end

   // R2: bits written to the set offset are present next cycle
   p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_set) |=>
         ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == $past(bus_wdata[NUM_LINES-1:0])));

   // R3: bits written to the clear offset are gone next cycle
   p_en_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && hit_clr) |=> ((en_q & $past(bus_wdata[NUM_LINES-1:0])) == '0));

   // R4: no interrupt output is active for a masked line
   p_out_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out != '0) |-> ((irq_out & ~en_q) == '0));

   // R10: a write to an unmapped or read-only offset leaves the mask alone
   p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && (!mapped || hit_req)) |=> $stable(en_q));

endmodule

// File: tb/ext_irq_ctrl_tb.sv
`timescale 1ns/1ps
module ext_irq_ctrl_tb;

   localparam int unsigned N = 32;
   localparam int unsigned AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_out;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   ext_irq_ctrl #(.NUM_LINES(N), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
      bus_we   = 1'b0;
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [AW-1:0] cfg_addr(input int line);
      return AW'('h180 + 4 * line);
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd('h000, v); chk("R1 request status", v, 0);
      rd('h004, v); chk("R1 enable via 0x004", v, 0);
      rd('h008, v); chk("R1 enable via 0x008", v, 0);
      rd('h100, v); chk("R1 detect", v, 0);
      rd(cfg_addr(0), v);  chk("R1 cfg line0", v, 0);
      rd(cfg_addr(31), v); chk("R1 cfg line31", v, 0);
      chk("R1 irq_out", irq_out, 0);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      wr('h008, 32'h0000_00F0);
      rd('h008, v); chk("R2 set read 0x008", v, 32'h0000_00F0);
      rd('h004, v); chk("R2 set read 0x004", v, 32'h0000_00F0);
      wr('h008, 32'h8000_0001);
      rd('h008, v); chk("R2 set keeps others", v, 32'h8000_00F1);
      wr('h004, 32'h0000_0030);
      rd('h004, v); chk("R3 clear subset", v, 32'h8000_00C1);
      wr('h004, 32'hFFFF_FFFF);
      rd('h008, v); chk("R3 clear all", v, 0);
   endtask

   task automatic t_config();
      logic [31:0] v;
      wr(cfg_addr(7), 32'hABCD_1208);
      rd(cfg_addr(7), v); chk("R9 cfg readback", v, 32'hABCD_1208);
      rd(cfg_addr(6), v); chk("R9 neighbour cfg untouched", v, 0);
      wr(cfg_addr(9), 32'h0000_0003);
      irq_in[9] = 1'b1; irq_in[10] = 1'b1;
      cyc(4);
      irq_in[9] = 1'b0; irq_in[10] = 1'b0;
      cyc(4);
      rd('h100, v); chk("R9 undefined/zero sense never detects", v & 32'h0000_0600, 0);
      wr(cfg_addr(7), 0);
   endtask

   task automatic t_rise();
      logic [31:0] v;
      wr('h100, 32'hFFFF_FFFF);
      wr(cfg_addr(3), 32'h08);
      wr(cfg_addr(4), 32'h08);
      wr('h008, 32'h0000_0008);
      irq_in[3] = 1'b1;
      cyc(2);
      rd('h100, v); chk("R5 not yet after two edges", v & 32'h8, 0);
      cyc(1);
      rd('h100, v); chk("R5 detect on third edge", v & 32'h8, 32'h8);
      rd('h000, v); chk("R4 request status", v & 32'h8, 32'h8);
      chk("R4 irq_out line3", 32'(irq_out[3]), 1);
      irq_in[3] = 1'b0;
      cyc(4);
      rd('h100, v); chk("R5 held after falling input", v & 32'h8, 32'h8);
      wr('h100, 32'h0000_0008);
      rd('h100, v); chk("R5 cleared by write one", v & 32'h8, 0);
      chk("R4 irq_out line3 drops", 32'(irq_out[3]), 0);
      irq_in[4] = 1'b1;
      cyc(3);
      rd('h100, v); chk("R4 detect while disabled", v & 32'h10, 32'h10);
      rd('h000, v); chk("R4 masked request", v & 32'h10, 0);
      chk("R4 masked irq_out", 32'(irq_out[4]), 0);
      wr('h008, 32'h0000_0010);
      chk("R4 enabling late raises irq_out", 32'(irq_out[4]), 1);
      irq_in[4] = 1'b0;
      wr('h004, 32'hFFFF_FFFF);
      wr('h100, 32'hFFFF_FFFF);
   endtask

   task automatic t_fall_both();
      logic [31:0] v;
      wr(cfg_addr(11), 32'h04);
      wr(cfg_addr(12), 32'h0C);
      irq_in[11] = 1'b1;
      cyc(4);
      rd('h100, v); chk("R6 falling ignores rise", v & 32'h800, 0);
      irq_in[11] = 1'b0;
      cyc(2);
      rd('h100, v); chk("R6 falling not yet", v & 32'h800, 0);
      cyc(1);
      rd('h100, v); chk("R6 falling detected", v & 32'h800, 32'h800);
      irq_in[12] = 1'b1;
      cyc(3);
      rd('h100, v); chk("R6 both: rise", v & 32'h1000, 32'h1000);
      wr('h100, 32'h0000_1000);
      rd('h100, v); chk("R6 both: cleared", v & 32'h1000, 0);
      irq_in[12] = 1'b0;
      cyc(3);
      rd('h100, v); chk("R6 both: fall", v & 32'h1000, 32'h1000);
      wr('h100, 32'hFFFF_FFFF);
   endtask

   task automatic t_collide();
      logic [31:0] v;
      wr(cfg_addr(5), 32'h08);
      irq_in[5] = 1'b1;
      cyc(2);
      wr('h100, 32'h0000_0020);
      rd('h100, v); chk("R7 edge wins over clear", v & 32'h20, 32'h20);
      wr('h100, 32'h0000_0020);
      rd('h100, v); chk("R7 later clear works", v & 32'h20, 0);
      irq_in[5] = 1'b0;
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(cfg_addr(13), 32'h02);
      irq_in[13] = 1'b1;
      cyc(3);
      rd('h100, v); chk("R8 high level detected", v & 32'h2000, 32'h2000);
      wr('h100, 32'h0000_2000);
      rd('h100, v); chk("R8 clear ignored while high", v & 32'h2000, 32'h2000);
      irq_in[13] = 1'b0;
      cyc(3);
      rd('h100, v); chk("R8 high level released", v & 32'h2000, 0);
      wr(cfg_addr(14), 32'h01);
      cyc(2);
      rd('h100, v); chk("R8 low level detected", v & 32'h4000, 32'h4000);
      irq_in[14] = 1'b1;
      cyc(3);
      rd('h100, v); chk("R8 low level released", v & 32'h4000, 0);
      wr(cfg_addr(14), 0);
      irq_in[14] = 1'b0;
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      wr('h008, 32'h0000_0101);
      wr('h00C, 32'hFFFF_FFFF);
      wr('h104, 32'hFFFF_FFFF);
      wr('h181, 32'hFFFF_FFFF);
      wr('h200, 32'hFFFF_FFFF);
      wr('h000, 32'hFFFF_FFFF);
      rd('h00C, v); chk("R10 0x00C reads zero", v, 0);
      rd('h104, v); chk("R10 0x104 reads zero", v, 0);
      rd('h200, v); chk("R10 beyond last line reads zero", v, 0);
      rd('h181, v); chk("R10 misaligned reads zero", v, 0);
      rd(cfg_addr(0), v); chk("R10 cfg line0 untouched", v, 0);
      rd('h008, v); chk("R10 enable untouched", v, 32'h0000_0101);
      rd('h100, v); chk("R10 detect untouched", v, 0);
   endtask

   initial begin
      #(8 * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      cyc(1);
      t_reset();
      t_enable();
      t_config();
      t_rise();
      t_fall_both();
      t_collide();
      t_level();
      t_unmapped();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule